// File: doc/BRIEF.md
# Commit-Stage Program Counter Shadow Checker

This block sits beside the commit stage of a processor pipeline. It holds its own copy of the architectural program counter and builds it only from what actually commits. Each committing instruction's address is compared with that copy. A difference means that something upstream has broken sequential control flow, for example fetch, decode, branch resolution or the reorder logic, and the block raises a one-cycle fault pulse.

After every commit the copy moves to the committed instruction's successor address. For an ordinary instruction that is the committed address plus its length, which is 2 or 4 bytes. For a taken control transfer it is the resolved target. A not-taken branch can use either path: the transfer flag with the fall-through address as its target, or no flag at all.

A separate load port writes the copy directly. It is used for the reset vector or for an exception entry, and the comparison is skipped in that cycle. After a mismatch the block takes its next value from the instruction that committed with the bad address, not from the stale copy. A single fault therefore gives one pulse and not a stream of them.

Top module: `retire_pc_check`

## Requirements
- R1: While reset (`rst_n` low) is applied and just after it is released, `expect_pc_o` equals the parameter `RESET_PC` (default 0x0000_0100) and `fault_o` is low.
- R2: A commit without the transfer flag (`cmt_xfer` = 0) whose `cmt_pc` matches sets `expect_pc_o` to `cmt_pc` + 2 one cycle later when `cmt_wide` = 0, and to `cmt_pc` + 4 when `cmt_wide` = 1.
- R3: A commit with `cmt_xfer` = 1 sets `expect_pc_o` to `cmt_target` one cycle later. A not-taken branch that gives its fall-through address as the target behaves like a sequential step.
- R4: A commit whose `cmt_pc` differs from `expect_pc_o` in the same cycle drives `fault_o` high in the next cycle only. `fault_o` is never high unless the previous cycle had a commit and no load.
- R5: A commit whose `cmt_pc` equals `expect_pc_o` leaves `fault_o` low in the next cycle.
- R6: After a mismatching commit, `expect_pc_o` becomes that instruction's successor address, computed from its own `cmt_pc`. A later commit at that address raises no fault.
- R7: When `redir_valid` is high, `expect_pc_o` becomes `redir_pc` one cycle later and `fault_o` stays low, even if a commit with a wrong address arrives in the same cycle.
- R8: In a cycle with neither a commit nor a load, `expect_pc_o` holds its value and `fault_o` is low in the next cycle.
- R9: Sequential steps wrap modulo 2^32. A 2-byte instruction at 0xFFFF_FFFE, or a 4-byte one at 0xFFFF_FFFC, gives an expected address of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| redir_valid | input | 1 | Load `redir_pc` into the expected address; skip checking this cycle |
| redir_pc | input | 32 | Address to load |
| cmt_valid | input | 1 | An instruction commits this cycle |
| cmt_pc | input | 32 | Address of the committing instruction |
| cmt_wide | input | 1 | Instruction length: 0 = 2 bytes, 1 = 4 bytes |
| cmt_xfer | input | 1 | Successor comes from `cmt_target` instead of a sequential step |
| cmt_target | input | 32 | Resolved successor address of a control transfer |
| fault_o | output | 1 | One-cycle pulse: the previous commit's address was not the expected one |
| expect_pc_o | output | 32 | Current expected address of the next commit |

## Verification
The assertions assume that the commit stage presents at most one instruction per cycle. They also assume that `cmt_wide`, `cmt_xfer` and `cmt_target` are meaningful only while `cmt_valid` is high, and that a load on `redir_valid` takes priority over any commit in the same cycle. The stimulus keeps to these assumptions. Every cycle carries either one commit or none, plus an optional load. Targets and load addresses are always even. Most commits use the exact address the reference model expects, and a minority use a deliberately changed address, so that the fault pulses and the resynchronisation after each one both occur often.

// File: rtl/rpc_pkg.sv
package rpc_pkg;

    localparam int unsigned RPC_PC_W        = 32;
    localparam int unsigned RPC_SHORT_BYTES = 2;
    localparam int unsigned RPC_LONG_BYTES  = 4;

    // How the expected address is updated this cycle, in priority order
    typedef enum logic [1:0] {
        UPD_HOLD  = 2'd0,
        UPD_SEQ   = 2'd1,
        UPD_XFER  = 2'd2,
        UPD_REDIR = 2'd3
    } upd_sel_e;

endpackage

// File: rtl/rpc_update_sel.sv
module rpc_update_sel
    import rpc_pkg::*;
(
    input  logic     redir_valid,
    input  logic     cmt_valid,
    input  logic     cmt_xfer,
    output upd_sel_e sel_o
);

    always_comb begin
        if (redir_valid) begin
            sel_o = UPD_REDIR;
        end else if (cmt_valid && cmt_xfer) begin
            sel_o = UPD_XFER;
        end else if (cmt_valid) begin
            sel_o = UPD_SEQ;
        end else begin
            sel_o = UPD_HOLD;
        end
    end

endmodule

// File: rtl/rpc_step_adder.sv
module rpc_step_adder #(
    parameter int unsigned PC_W        = 32,
    parameter int unsigned SHORT_BYTES = 2,
    parameter int unsigned LONG_BYTES  = 4
) (
    input  logic [PC_W-1:0] base_i,
    input  logic            wide_i,
    output logic [PC_W-1:0] sum_o
);

    localparam logic [PC_W-1:0] SHORT_INC = PC_W'(SHORT_BYTES);
    localparam logic [PC_W-1:0] LONG_INC  = PC_W'(LONG_BYTES);

    logic [PC_W-1:0] inc;

    always_comb begin
        inc   = wide_i ? LONG_INC : SHORT_INC;
        sum_o = base_i + inc;   // wraps modulo 2^PC_W
    end

endmodule

// File: rtl/rpc_pc_compare.sv
module rpc_pc_compare #(
    parameter int unsigned PC_W   = 32,
    parameter int unsigned LANE_W = 8
) (
    input  logic [PC_W-1:0] a_i,
    input  logic [PC_W-1:0] b_i,
    output logic            differ_o
);

    localparam int unsigned NLANE = (PC_W + LANE_W - 1) / LANE_W;

    logic [NLANE-1:0] lane_diff;

    // Lane-wise xor reduction keeps the OR tree shallow
    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        localparam int unsigned LO = g * LANE_W;
        localparam int unsigned HI = ((g + 1) * LANE_W > PC_W) ? PC_W - 1
                                                                : (g + 1) * LANE_W - 1;
        always_comb begin
            lane_diff[g] = |(a_i[HI:LO] ^ b_i[HI:LO]);
        end
    end

    always_comb begin
        differ_o = |lane_diff;
    end

endmodule

// File: rtl/retire_pc_check.sv
module retire_pc_check
    import rpc_pkg::*;
#(
    parameter int unsigned    PC_W        = RPC_PC_W,
    parameter int unsigned    SHORT_BYTES = RPC_SHORT_BYTES,
    parameter int unsigned    LONG_BYTES  = RPC_LONG_BYTES,
    parameter logic [PC_W-1:0] RESET_PC   = PC_W'(32'h0000_0100)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            redir_valid,
    input  logic [PC_W-1:0] redir_pc,
    input  logic            cmt_valid,
    input  logic [PC_W-1:0] cmt_pc,
    input  logic            cmt_wide,
    input  logic            cmt_xfer,
    input  logic [PC_W-1:0] cmt_target,
    output logic            fault_o,
    output logic [PC_W-1:0] expect_pc_o
);

    localparam logic [PC_W-1:0] SHORT_STEP = PC_W'(SHORT_BYTES);
    localparam logic [PC_W-1:0] LONG_STEP  = PC_W'(LONG_BYTES);

    typedef struct packed {
        logic [PC_W-1:0] exp_pc;
        logic            fault;
    } chk_state_t;

    chk_state_t      state_d, state_q;
    upd_sel_e        sel;
    logic [PC_W-1:0] seq_pc;
    logic            pc_differs;

    rpc_update_sel u_sel (
        .redir_valid (redir_valid),
        .cmt_valid   (cmt_valid),
        .cmt_xfer    (cmt_xfer),
        .sel_o       (sel)
    );

    // Successor is built from the committed address itself (resync on fault)
    rpc_step_adder #(
        .PC_W        (PC_W),
        .SHORT_BYTES (SHORT_BYTES),
        .LONG_BYTES  (LONG_BYTES)
    ) u_add (
        .base_i (cmt_pc),
        .wide_i (cmt_wide),
        .sum_o  (seq_pc)
    );

    rpc_pc_compare #(
        .PC_W   (PC_W),
        .LANE_W (8)
    ) u_cmp (
        .a_i      (cmt_pc),
        .b_i      (state_q.exp_pc),
        .differ_o (pc_differs)
    );

    always_comb begin
        state_d       = state_q;
        state_d.fault = 1'b0;
        unique case (sel)
            UPD_REDIR: begin
                state_d.exp_pc = redir_pc;
            end
            UPD_XFER: begin
                state_d.exp_pc = cmt_target;
                state_d.fault  = pc_differs;
            end
            UPD_SEQ: begin
                state_d.exp_pc = seq_pc;
                state_d.fault  = pc_differs;
            end
            default: begin
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '{exp_pc: RESET_PC, fault: 1'b0};
        end else begin
            state_q <= state_d;
        end
    end

    assign fault_o     = state_q.fault;
    assign expect_pc_o = state_q.exp_pc;

    // R2
    seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmt_valid && !redir_valid && !cmt_xfer |=>
            expect_pc_o == $past(cmt_pc) + ($past(cmt_wide) ? LONG_STEP : SHORT_STEP));

    // R3
    xfer_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmt_valid && !redir_valid && cmt_xfer |=> expect_pc_o == $past(cmt_target));

    // R4
    fault_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> $past(cmt_valid) && !$past(redir_valid));

    // R4
    fault_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmt_valid && !redir_valid && cmt_pc != expect_pc_o |=> fault_o);

    // R5
    match_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmt_valid && cmt_pc == expect_pc_o |=> !fault_o);

    // R7
    redirect_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redir_valid |=> expect_pc_o == $past(redir_pc) && !fault_o);

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmt_valid && !redir_valid |=> $stable(expect_pc_o) && !fault_o);

endmodule

// File: tb/retire_pc_check_bench.sv
`timescale 1ns/1ps
module retire_pc_check_bench;

    localparam logic [31:0] RST_PC = 32'h0000_0100;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        redir_valid;
    logic [31:0] redir_pc;
    logic        cmt_valid;
    logic [31:0] cmt_pc;
    logic        cmt_wide;
    logic        cmt_xfer;
    logic [31:0] cmt_target;
    logic        fault_o;
    logic [31:0] expect_pc_o;

    int          n_run  = 0;
    int          n_fail = 0;
    logic [31:0] m_exp;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    retire_pc_check u_retire_pc_check (
        .clk         (clk),
        .rst_n       (rst_n),
        .redir_valid (redir_valid),
        .redir_pc    (redir_pc),
        .cmt_valid   (cmt_valid),
        .cmt_pc      (cmt_pc),
        .cmt_wide    (cmt_wide),
        .cmt_xfer    (cmt_xfer),
        .cmt_target  (cmt_target),
        .fault_o     (fault_o),
        .expect_pc_o (expect_pc_o)
    );

    function automatic logic [31:0] model_next(logic [31:0] pc, logic wide,
                                               logic xfer, logic [31:0] tgt);
        return xfer ? tgt : pc + (wide ? 32'd4 : 32'd2);
    endfunction

    task automatic check(string req, logic [31:0] exp_pc, logic exp_f);
        n_run++;
        if (expect_pc_o !== exp_pc || fault_o !== exp_f) begin
            n_fail++;
            $display("FAIL %s: expect_pc_o=%h fault_o=%b, wanted %h / %b",
                     req, expect_pc_o, fault_o, exp_pc, exp_f);
        end
    endtask

    // Drive one cycle at a falling edge, then check at the next falling edge
    task automatic cycle(string req, logic rv, logic [31:0] rpc, logic cv,
                         logic [31:0] cpc, logic w, logic x, logic [31:0] tgt);
        logic [31:0] n_pc;
        logic        n_f;
        redir_valid = rv; redir_pc = rpc; cmt_valid = cv; cmt_pc = cpc;
        cmt_wide = w; cmt_xfer = x; cmt_target = tgt;
        if (rv) begin
            n_pc = rpc; n_f = 1'b0;
        end else if (cv) begin
            n_pc = model_next(cpc, w, x, tgt); n_f = (cpc != m_exp);
        end else begin
            n_pc = m_exp; n_f = 1'b0;
        end
        @(negedge clk);
        check(req, n_pc, n_f);
        m_exp = n_pc;
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: run hung, wanted completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        rst_n = 1'b0; redir_valid = 0; redir_pc = 0; cmt_valid = 0;
        cmt_pc = 0; cmt_wide = 0; cmt_xfer = 0; cmt_target = 0;
        repeat (3) @(negedge clk);
        check("R1", RST_PC, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", RST_PC, 1'b0);
        m_exp = RST_PC;

        cycle("R8", 0, 0, 0, 0, 0, 0, 0);
        cycle("R2", 0, 0, 1, m_exp, 0, 0, 0);              // +2
        cycle("R2", 0, 0, 1, m_exp, 1, 0, 0);              // +4
        cycle("R5", 0, 0, 1, m_exp, 1, 0, 0);
        cycle("R3", 0, 0, 1, m_exp, 1, 1, 32'h0000_2000);
        cycle("R3", 0, 0, 1, m_exp, 1, 1, m_exp + 32'd4);   // not-taken
        cycle("R4", 0, 0, 1, m_exp + 32'd8, 0, 0, 0);      // mismatch
        cycle("R6", 0, 0, 1, m_exp, 0, 0, 0);              // resynced
        cycle("R4", 0, 0, 0, 0, 0, 0, 0);
        cycle("R8", 0, 0, 0, 0, 0, 0, 0);
        cycle("R7", 1, 32'h0000_8000, 1, 32'h1234_5678, 0, 0, 0);
        cycle("R5", 0, 0, 1, m_exp, 0, 0, 0);
        cycle("R7", 1, 32'hFFFF_FFFE, 0, 0, 0, 0, 0);
        cycle("R9", 0, 0, 1, m_exp, 0, 0, 0);
        cycle("R7", 1, 32'hFFFF_FFFC, 0, 0, 0, 0, 0);
        cycle("R9", 0, 0, 1, m_exp, 1, 0, 0);

        for (int i = 0; i < 600; i++) begin
            int unsigned r = $urandom % 100;
            if (r < 6) begin
                cycle("R7", 1, $urandom & 32'hFFFF_FFFE, $urandom % 2, $urandom & 32'hFFFF_FFFE,
                      $urandom % 2, $urandom % 2, $urandom & 32'hFFFF_FFFE);
            end else if (r < 18) begin
                cycle("R8", 0, 0, 0, 0, 0, 0, 0);
            end else begin
                logic [31:0] pc  = m_exp;
                logic        bad = ($urandom % 100) < 12;
                if (bad) pc = m_exp ^ (32'h2 << ($urandom % 8));
                cycle(bad ? "R6" : "R2", 0, 0, 1, pc, $urandom % 2,
                      ($urandom % 100) < 30, $urandom & 32'hFFFF_FFFE);
            end
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule